// File: doc/BRIEF.md
# Register/Memory Poll-Wait Unit

This block carries out one wait command taken from a stream of 32-bit command words. It takes five payload words: control, poll address, reference, mask and wait interval. It then reads a value from either the register file or external memory. It ANDs that value with the mask and compares it, unsigned, against the reference using one of seven relations. The command completes only when that relation holds. Until then the unit re-reads the source, pausing a programmable number of cycles between reads, and it accepts no further command words.

The register file is read through a combinational read port: an address and a strobe go out, and the data comes back in the same cycle. Memory is read through a request/response pair with any latency. Words returned from memory are big-endian. The unit signals completion with a one-cycle `done` pulse. Malformed commands raise a sticky `err` flag and complete at once.

Top module: `pollwait_unit`

## Requirements
- R1: Out of reset and between commands `cmd_ready` is 1. The unit takes five words, one per cycle in which `cmd_valid` and `cmd_ready` are both 1. The words come in this order: control, poll address, reference, mask, interval.
- R2: `cmd_ready` is 0 from the cycle after the fifth word is accepted through the cycle in which `done` is 1. Words offered in that time are not consumed.
- R3: Control bit 4 picks the source: 1 reads memory at the poll address, 0 reads register-file entry poll address. The unread source is never accessed.
- R4: Control bits [2:0] pick the relation between (value AND mask) and the unmasked reference, compared unsigned: 0 always true, 1 less-than, 2 less-or-equal, 3 equal, 4 not-equal, 5 greater-or-equal, 6 greater-than.
- R5: When the relation fails, the source is read again interval+1 cycles after the previous read. An interval of 0 means a read on every cycle.
- R6: `done` is a one-cycle pulse. For a register source whose first read passes, it is 1 in the second cycle after the fifth word is accepted.
- R7: Code 7 sets `err` and completes, with the same timing as R6, without any register or memory read.
- R8: A register-source poll address of NUM_REGS (48 by default) or above sets `err` and completes without a read. Address NUM_REGS-1 is read normally.
- R9: In a memory response, the byte from the lowest address sits in bits [7:0]. The unit builds the polled value with that byte as the most significant byte.
- R10: Each memory poll issues exactly one single-cycle `mem_req` with `mem_addr` equal to the poll address. The unit then waits for `mem_rsp_valid`.
- R11: After reset `done`, `err`, `mem_req` and `reg_rd_en` are 0. Once set, `err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_data | input | DW | Command word |
| cmd_ready | output | 1 | Command word accepted this cycle when valid |
| reg_rd_en | output | 1 | Register-file read strobe |
| reg_rd_addr | output | REG_AW | Register-file read index |
| reg_rd_data | input | DW | Register-file read data, same cycle |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | DW | Memory read address |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_data | input | DW | Memory response, lowest-address byte in [7:0] |
| done | output | 1 | Command completed (one cycle) |
| err | output | 1 | Sticky malformed-command flag |

## Verification
A corrupted compare code or a mask that is not applied shows up as `done` being early or missing. This is visible two cycles after the last payload word for a register poll. A broken interval counter changes the spacing between `reg_rd_en` strobes, which shows on the second read of a failing poll. A broken byte order or source select shows up as a memory poll that never passes, or as a stray strobe on the port that should have stayed idle.

// File: rtl/pollwait_pkg.sv
// Shared types for the poll-wait unit.
// Assumes: payload order and control-field positions are fixed by the command format.
package pollwait_pkg;

    // Relation selected by control bits [2:0]
    typedef enum logic [2:0] {
        CMP_ALWAYS = 3'd0,
        CMP_LT     = 3'd1,
        CMP_LE     = 3'd2,
        CMP_EQ     = 3'd3,
        CMP_NE     = 3'd4,
        CMP_GE     = 3'd5,
        CMP_GT     = 3'd6,
        CMP_RSVD   = 3'd7
    } cmp_code_t;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_LOAD   = 3'd0,
        ST_POLL   = 3'd1,
        ST_MEMRSP = 3'd2,
        ST_WAIT   = 3'd3,
        ST_DONE   = 3'd4
    } pw_state_t;

    // Payload word positions
    localparam int W_CTRL   = 0;
    localparam int W_ADDR   = 1;
    localparam int W_REF    = 2;
    localparam int W_MASK   = 3;
    localparam int W_INTV   = 4;
    localparam int W_LAST   = W_INTV;

    localparam int CTRL_SRC_BIT = 4;
    localparam int CTRL_CMP_W   = 3;

endpackage

// File: rtl/pw_compare.sv
// Masked unsigned relational compare.
// Does: ANDs value with mask and applies the selected relation against refv.
// Assumes: the reserved code is trapped by the caller; it yields pass=0 here.
module pw_compare
    import pollwait_pkg::*;
#(
    parameter int DW = 32
) (
    input  cmp_code_t         code,
    input  logic [DW-1:0]     value,
    input  logic [DW-1:0]     mask,
    input  logic [DW-1:0]     refv,
    output logic              pass
);

    logic [DW-1:0] masked;

    // Apply the relation to the masked value
    always_comb begin
        masked = value & mask;
        unique case (code)
            CMP_ALWAYS: pass = 1'b1;
            CMP_LT:     pass = masked <  refv;
            CMP_LE:     pass = masked <= refv;
            CMP_EQ:     pass = masked == refv;
            CMP_NE:     pass = masked != refv;
            CMP_GE:     pass = masked >= refv;
            CMP_GT:     pass = masked >  refv;
            default:    pass = 1'b0;
        endcase
    end

endmodule

// File: rtl/pw_interval.sv
// Down-counter that spaces retries.
// Does: loads a count and, while run is high, decrements it to zero.
// Assumes: load and run are never high in the same cycle.
module pw_interval #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // Load or count down the pause
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign expired = (cnt_q == '0);

    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/pollwait_unit.sv
// Poll-wait command unit.
// Does: gathers a five-word wait command, polls a register or memory word,
// compares it under a mask and completes once the relation holds.
// Assumes: register reads return data in the same cycle; memory answers each
// request with exactly one response, after any latency.
module pollwait_unit
    import pollwait_pkg::*;
#(
    parameter  int DW             = 32,
    parameter  int NUM_REGS       = 48,
    parameter  int MEM_BIG_ENDIAN = 1,
    localparam int REG_AW         = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [DW-1:0]     cmd_data,
    output logic              cmd_ready,
    output logic              reg_rd_en,
    output logic [REG_AW-1:0] reg_rd_addr,
    input  logic [DW-1:0]     reg_rd_data,
    output logic              mem_req,
    output logic [DW-1:0]     mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [DW-1:0]     mem_rsp_data,
    output logic              done,
    output logic              err
);

    localparam int NBYTES = DW / 8;

    pw_state_t      st_q;
    logic [2:0]     widx_q;
    logic           src_mem_q;
    cmp_code_t      code_q;
    logic [DW-1:0]  addr_q, ref_q, mask_q, intv_q;
    logic [DW-1:0]  mem_val, poll_val;
    logic           pass, bad_code, bad_addr, sample_ok, sample_fail;
    logic           tmr_load, tmr_expired;

    // Byte order of memory words
    generate
        if (MEM_BIG_ENDIAN != 0) begin : g_swap
            for (genvar b = 0; b < NBYTES; b++) begin : g_byte
                assign mem_val[DW-1-8*b -: 8] = mem_rsp_data[8*b+7 -: 8];
            end
        end else begin : g_noswap
            assign mem_val = mem_rsp_data;
        end
    endgenerate

    // Decode malformed commands and the current sample
    always_comb begin
        bad_code    = (code_q == CMP_RSVD);
        bad_addr    = !src_mem_q && (addr_q >= DW'(NUM_REGS));
        poll_val    = (st_q == ST_MEMRSP) ? mem_val : reg_rd_data;
        sample_ok   = ((st_q == ST_POLL) && !src_mem_q && !bad_code && !bad_addr)
                   || ((st_q == ST_MEMRSP) && mem_rsp_valid);
        sample_fail = sample_ok && !pass;
        tmr_load    = sample_fail && (intv_q != '0);
    end

    pw_compare #(.DW(DW)) i_cmp (
        .code  (code_q),
        .value (poll_val),
        .mask  (mask_q),
        .refv  (ref_q),
        .pass  (pass)
    );

    pw_interval #(.CW(DW)) i_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (intv_q - DW'(1)),
        .run      (st_q == ST_WAIT),
        .expired  (tmr_expired)
    );

    // Capture payload words into their fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_mem_q <= 1'b0;
            code_q    <= CMP_ALWAYS;
            addr_q    <= '0;
            ref_q     <= '0;
            mask_q    <= '0;
            intv_q    <= '0;
        end else if (st_q == ST_LOAD && cmd_valid) begin
            case (widx_q)
                3'(W_CTRL): begin
                    src_mem_q <= cmd_data[CTRL_SRC_BIT];
                    code_q    <= cmp_code_t'(cmd_data[CTRL_CMP_W-1:0]);
                end
                3'(W_ADDR): addr_q <= cmd_data;
                3'(W_REF):  ref_q  <= cmd_data;
                3'(W_MASK): mask_q <= cmd_data;
                default:    intv_q <= cmd_data;
            endcase
        end
    end

    // Sequence loading, polling, pausing and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_LOAD;
            widx_q <= '0;
            err    <= 1'b0;
        end else begin
            unique case (st_q)
                ST_LOAD: if (cmd_valid) begin
                    if (widx_q == 3'(W_LAST)) begin
                        widx_q <= '0;
                        st_q   <= ST_POLL;
                    end else begin
                        widx_q <= widx_q + 3'd1;
                    end
                end
                ST_POLL: begin
                    if (bad_code || bad_addr) begin
                        err  <= 1'b1;
                        st_q <= ST_DONE;
                    end else if (src_mem_q)
                        st_q <= ST_MEMRSP;
                    else if (pass)
                        st_q <= ST_DONE;
                    else if (intv_q != '0)
                        st_q <= ST_WAIT;
                end
                ST_MEMRSP: if (mem_rsp_valid) begin
                    if (pass)
                        st_q <= ST_DONE;
                    else if (intv_q != '0)
                        st_q <= ST_WAIT;
                    else
                        st_q <= ST_POLL;
                end
                ST_WAIT: if (tmr_expired) st_q <= ST_POLL;
                default: st_q <= ST_LOAD;
            endcase
        end
    end

    assign cmd_ready   = (st_q == ST_LOAD);
    assign done        = (st_q == ST_DONE);
    assign reg_rd_en   = (st_q == ST_POLL) && !src_mem_q && !bad_code && !bad_addr;
    assign reg_rd_addr = addr_q[REG_AW-1:0];
    assign mem_req     = (st_q == ST_POLL) && src_mem_q && !bad_code;
    assign mem_addr    = addr_q;

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_ready);
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    a_r10_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    a_r3_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && reg_rd_en));
    a_r8_read_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> (addr_q < DW'(NUM_REGS)));
    a_r7_no_poll_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en || mem_req) |-> (code_q != CMP_RSVD));

endmodule

// File: tb/test_pollwait_unit.sv
module test_pollwait_unit;

    localparam int DW = 32;
    localparam int NREG = 48;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [31:0] cmd_data = '0;
    logic cmd_ready, reg_rd_en, mem_req, done, err;
    logic [5:0] reg_rd_addr;
    logic [31:0] reg_rd_data, mem_addr;
    logic mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    logic [31:0] rf [64];
    logic [31:0] mem_word = '0;
    int checks = 0, errors = 0;
    int cyc = 0, rd_count = 0, prev_rd = -1, last_gap = 0;
    int mem_count = 0, pend = 0;
    logic [31:0] last_mem_addr = '0;

    always #5 clk = ~clk;

    assign reg_rd_data = rf[reg_rd_addr];

    pollwait_unit #(.DW(DW), .NUM_REGS(NREG)) i_pollwait_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr),
        .reg_rd_data(reg_rd_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .err(err));

    function automatic logic [31:0] to_lanes(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic bit exp_pass(input int code, input logic [31:0] v, m, r);
        logic [31:0] x;
        x = v & m;
        case (code)
            0: return 1'b1;
            1: return x < r;
            2: return x <= r;
            3: return x == r;
            4: return x != r;
            5: return x >= r;
            6: return x > r;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit find_rescue(input int code, input logic [31:0] m, r,
                                       output logic [31:0] val);
        logic [31:0] cand [3];
        cand[0] = 32'h0; cand[1] = r; cand[2] = m;
        val = '0;
        for (int i = 0; i < 3; i++)
            if (exp_pass(code, cand[i], m, r)) begin
                val = cand[i];
                return 1'b1;
            end
        return 1'b0;
    endfunction

    // Cycle counter and read-strobe spacing monitor
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (reg_rd_en) begin
            if (prev_rd >= 0) last_gap = cyc - prev_rd;
            prev_rd = cyc;
            rd_count++;
        end
    end

    // Memory model with fixed latency
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req) begin
            pend <= LAT;
            mem_count <= mem_count + 1;
            last_mem_addr <= mem_addr;
        end else if (pend > 0) begin
            pend <= pend - 1;
            if (pend == 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= to_lanes(mem_word);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [31:0] c, a, r, m, iv);
        logic [31:0] w [5];
        bit rdy_ok;
        w[0] = c; w[1] = a; w[2] = r; w[3] = m; w[4] = iv;
        rdy_ok = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            cmd_valid = 1'b1;
            cmd_data  = w[i];
            if (!cmd_ready) rdy_ok = 1'b0;
            @(posedge clk);
        end
        chk(rdy_ok, "R1", "ready during payload", 32'(rdy_ok), 1);
    endtask

    task automatic wait_done(input int maxn, output int n);
        n = 0;
        while (n < maxn) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            n++;
            if (done) return;
        end
        n = -1;
    endtask

    task automatic stall_probe(input int ncyc, output bit ok);
        ok = 1'b1;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            cmd_valid = 1'b1;
            cmd_data  = $urandom;
            if (cmd_ready || done) ok = 1'b0;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        if (cmd_ready || done) ok = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, rd0, mc0;
        bit ok;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) rf[i] = '0;
        do_reset();
        @(negedge clk);
        chk(cmd_ready && !done && !err && !mem_req && !reg_rd_en, "R11", "reset outputs",
            {27'd0, cmd_ready, done, err, mem_req, reg_rd_en}, 32'h10);

        // R4: mask applies to the value only
        rf[5] = 32'hF5;
        send(32'h3, 32'd5, 32'h05, 32'h0F, 32'd0);
        wait_done(6, n);
        chk(n == 2, "R6", "done cycle masked equal", n, 2);
        chk(!err, "R4", "no error on good compare", err, 0);

        rf[6] = 32'h05;
        send(32'h3, 32'd6, 32'hF5, 32'h0F, 32'd1);
        stall_probe(6, ok);
        chk(ok, "R4", "unmasked reference never matches", 32'(ok), 1);
        rf[6] = 32'hFF;
        wait_done(6, n);
        chk(n == -1, "R4", "still waiting", n, -1);
        do_reset();

        // Random register polls
        for (int t = 0; t < 40; t++) begin
            int code, addr, iv;
            logic [31:0] m, r, v, rv;
            bit p, have;
            do begin
                code = $urandom % 7;
                addr = $urandom % NREG;
                iv   = $urandom % 5;
                m    = (t % 2 == 0) ? 32'h0000_00FF : $urandom;
                r    = $urandom & m;
                v    = $urandom;
                p    = exp_pass(code, v, m, r);
                have = find_rescue(code, m, r, rv);
            end while (!(p || have));
            rf[addr] = v;
            rd0 = rd_count;
            send({27'd0, 2'b00, 3'(code)}, 32'(addr), r, m, 32'(iv));
            if (p) begin
                wait_done(6, n);
                chk(n == 2, "R6", "done timing on first pass", n, 2);
                chk(rd_count == rd0 + 1, "R4", "single read on pass", rd_count - rd0, 1);
            end else begin
                stall_probe(2 * iv + 4, ok);
                chk(ok, "R2", "stalled and not ready", 32'(ok), 1);
                chk(last_gap == iv + 1, "R5", "retry spacing", last_gap, iv + 1);
                rf[addr] = rv;
                wait_done(iv + 4, n);
                chk(n > 0, "R4", "completes after rescue", n, 1);
            end
            chk(!err, "R4", "no error on valid code", err, 0);
        end

        // Memory source with big-endian assembly
        mem_word = 32'h0102_0304;
        rd0 = rd_count;
        mc0 = mem_count;
        send(32'h13, 32'h0000_0005, 32'h0102_0304, 32'hFFFF_FFFF, 32'd0);
        wait_done(12, n);
        chk(n > 0, "R9", "big-endian value matched", n, 1);
        chk(mem_count == mc0 + 1, "R10", "one request", mem_count - mc0, 1);
        chk(last_mem_addr == 32'h5, "R10", "request address", last_mem_addr, 32'h5);
        chk(rd_count == rd0, "R3", "no register read for memory", rd_count - rd0, 0);

        mem_word = 32'h0102_0304;
        send(32'h13, 32'h0000_0008, 32'h0403_0201, 32'hFFFF_FFFF, 32'd0);
        stall_probe(8, ok);
        chk(ok, "R9", "swapped order does not match", 32'(ok), 1);
        do_reset();

        // Memory retry
        mem_word = 32'h0;
        mc0 = mem_count;
        send(32'h16, 32'h0000_0100, 32'h10, 32'hFFFF_FFFF, 32'd2);
        stall_probe(14, ok);
        chk(ok, "R2", "memory poll stalls", 32'(ok), 1);
        chk(mem_count - mc0 >= 2, "R10", "repeated requests", mem_count - mc0, 2);
        mem_word = 32'h20;
        wait_done(12, n);
        chk(n > 0, "R10", "memory retry completes", n, 1);

        // Register source ignores memory
        mc0 = mem_count;
        rf[7] = 32'h9;
        send(32'h05, 32'd7, 32'h9, 32'hF, 32'd0);
        wait_done(6, n);
        chk(n == 2 && mem_count == mc0, "R3", "register poll no memory", mem_count - mc0, 0);

        // Address bounds
        rf[NREG-1] = 32'h1;
        send(32'h3, 32'(NREG - 1), 32'h1, 32'hFFFF_FFFF, 32'd0);
        wait_done(6, n);
        chk(n == 2 && !err, "R8", "last register ok", {31'd0, err}, 0);
        rd0 = rd_count;
        send(32'h0, 32'(NREG), 32'h0, 32'h0, 32'd0);
        wait_done(6, n);
        chk(n == 2 && err, "R8", "out of range errors", {31'd0, err}, 1);
        chk(rd_count == rd0, "R8", "no read out of range", rd_count - rd0, 0);
        do_reset();

        // Reserved code
        rd0 = rd_count;
        mc0 = mem_count;
        send(32'h17, 32'h40, 32'h0, 32'h0, 32'd3);
        wait_done(6, n);
        chk(n == 2, "R7", "reserved code completes", n, 2);
        chk(err, "R7", "reserved code error", err, 1);
        chk(rd_count == rd0 && mem_count == mc0, "R7", "no poll", mem_count - mc0, 0);
        rf[1] = 32'h0;
        send(32'h0, 32'd1, 32'h0, 32'h0, 32'd0);
        wait_done(6, n);
        @(negedge clk);
        chk(err && cmd_ready, "R11", "error sticky", {31'd0, err}, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule